// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a flow-through synchronous SRAM whose bus can switch between reads and writes on every clock with no idle cycle. It is backed by a small internal word array. Address, command and lane enables are registered on the rising edge. Read data flows straight from the array to the output during the following cycle. Write data is presented one cycle after its address and parks in a pending-write register until the next working edge moves it into the array.

Reads that target the parked word get the newest bytes, merged lane by lane. A clock-enable stall freezes the command register, the pending write and the bus drive state. Three chip enables deselect the device on load cycles. A short burst of four addresses can follow a load, in either linear or interleaved order.

Top module: `nowait_sram`

## Requirements
- R1: Inputs take effect only at a rising edge where `clk_en_n` is low. On such an edge with `load_n` low, `wr_n` low starts a write and `wr_n` high starts a read at `addr`.
- R2: A load edge selects the device only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. Otherwise the cycle is a deselect: `dout_en` is 0 and the following `din` writes nothing.
- R3: For a selected read, the addressed word appears on `dout` with `dout_en`=1 during the cycle after the edge that registered the address, provided `oe_n` is low. `oe_n` high forces `dout_en` to 0 at once.
- R4: Write data is taken from `din` at the next unstalled edge after the write address. Lane i (bits 8i+7:8i) is written only when `lane_en_n[i]` was 0 at the address edge. A lane whose bit was 1 keeps its old value.
- R5: A write with `lane_en_n` all ones changes no memory word.
- R6: A read of the word whose write data was captured at the same edge returns the new bytes in the enabled lanes and the array bytes in the others.
- R7: During a write cycle `dout_en` is 0 whatever the level of `oe_n`.
- R8: An edge with `clk_en_n` high is ignored. Nothing is written, `din` is not taken, the burst does not advance, and `dout_en`/`dout` keep their values.
- R9: An edge with `load_n` high continues the burst and keeps its read/write type, whatever `wr_n` shows. The step count k counts 0,1,2,3 and wraps. The low two address bits are (start+k) mod 4 when `interleave` was 0 at the load, and start XOR k when it was 1. Upper bits are unchanged.
- R10: A continue edge while deselected leaves the device deselected.
- R11: After reset the device is deselected, no write is pending and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Low: edge is used; high: edge ignored (stall) |
| sel_a_n | input | 1 | Active-low chip enable A |
| sel_b_n | input | 1 | Active-low chip enable B |
| sel_c | input | 1 | Active-high chip enable C |
| load_n | input | 1 | Low: load new address; high: continue burst |
| wr_n | input | 1 | Low: write, high: read (load edges only) |
| lane_en_n | input | 2 | Active-low byte lane write enables |
| addr | input | 8 | Word address |
| interleave | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| din | input | 16 | Write data, one cycle after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | 16 | Read data (zero when not driven) |
| dout_en | output | 1 | High when the data bus is driven |

## Verification
A stale or lost pending write shows at the ports as wrong bytes in the very next read of that word. This holds whether the read comes back-to-back, so it is served from the parked register, or one edge later, so it is served from the array. A burst counter that drifts or a command register that moves during a stall gives a wrong word or a wrong `dout_en` in the cycle right after the faulty edge. The bench compares every cycle against a byte-level memory model. It places write-then-read pairs, partial-lane and aborted writes, stalls and deselects so that each such fault is visible within one cycle.

// File: rtl/nowait_sram_pkg.sv
// Package: shared cycle-type encoding for the zero-turnaround SRAM.
// Assumes: nothing beyond IEEE 1800-2017.
package nowait_sram_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_t;

endpackage

// File: rtl/nowait_burst_gen.sv
// Burst address generator: returns the low address bits for step k of a
// burst that started at 'start', in linear (start+k) or interleaved
// (start^k) order. Purely combinational.
// Assumes: step wraps naturally at 2**CNT_W.
module nowait_burst_gen #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] step,
    input  logic             interleave,
    output logic [CNT_W-1:0] low
);

    // Select the burst ordering.
    always_comb begin
        if (interleave) low = start ^ step;
        else            low = start + step;
    end

endmodule

// File: rtl/nowait_cmd_stage.sv
// Command stage: registers the cycle type, base address, burst step and
// lane enables on every working edge; continue edges advance the burst.
// Assumes: ADDR_W > CNT_W; adv is the inverted clock enable.
module nowait_cmd_stage
    import nowait_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              load_n,
    input  logic              wr_n,
    input  logic              selected,
    input  logic              interleave,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic [ADDR_W-1:0] addr,
    output cyc_t              cyc,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LANES-1:0]  cur_lanes_n
);

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  step_q;
    logic              mode_q;
    logic [CNT_W-1:0]  low_bits;

    nowait_burst_gen #(.CNT_W(CNT_W)) u_gen (
        .start      (base_q[CNT_W-1:0]),
        .step       (step_q),
        .interleave (mode_q),
        .low        (low_bits)
    );

    assign cur_addr = {base_q[ADDR_W-1:CNT_W], low_bits};

    // Capture a new command on load edges, advance the burst on continue edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc         <= CYC_IDLE;
            base_q      <= '0;
            step_q      <= '0;
            mode_q      <= 1'b0;
            cur_lanes_n <= '1;
        end else if (adv) begin
            cur_lanes_n <= lane_en_n;
            if (!load_n) begin
                cyc    <= !selected ? CYC_IDLE : (wr_n ? CYC_READ : CYC_WRITE);
                base_q <= addr;
                step_q <= '0;
                mode_q <= interleave;
            end else if (cyc != CYC_IDLE) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // R8: a stalled edge leaves the command untouched.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(cur_addr) && $stable(cyc)));

    // R10: continuing while deselected stays deselected.
    p_cont_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && load_n && cyc == CYC_IDLE) |=> cyc == CYC_IDLE);

    // R9: a burst keeps its type and its aligned block.
    p_burst_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && load_n && cyc != CYC_IDLE) |=>
            (cyc == $past(cyc) &&
             cur_addr[ADDR_W-1:CNT_W] == $past(cur_addr[ADDR_W-1:CNT_W])));

endmodule

// File: rtl/nowait_write_buf.sv
// Pending-write register and read forwarding: holds the last write whose
// data has arrived but is not yet in the array, and merges it byte by byte
// into reads of the same word.
// Assumes: the array commits pend_* on the next edge where adv is high.
module nowait_write_buf #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic                    take,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lanes_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [LANES*LANE_W-1:0] arr_word,
    output logic                    pend_valid,
    output logic [ADDR_W-1:0]       pend_addr,
    output logic [LANES-1:0]        pend_mask,
    output logic [LANES*LANE_W-1:0] pend_data,
    output logic [LANES*LANE_W-1:0] rd_word
);

    logic hit;

    // Park the data of the write registered at the previous working edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_mask  <= '0;
            pend_data  <= '0;
        end else if (adv) begin
            pend_valid <= take;
            if (take) begin
                pend_addr <= wr_addr;
                pend_mask <= ~wr_lanes_n;
                pend_data <= wr_data;
            end
        end
    end

    assign hit = pend_valid && (pend_addr == rd_addr);

    // Per-lane merge of parked bytes over array bytes.
    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign rd_word[g*LANE_W +: LANE_W] =
            (hit && pend_mask[g]) ? pend_data[g*LANE_W +: LANE_W]
                                  : arr_word[g*LANE_W +: LANE_W];
    end

    // R4: a write command always yields a parked data word next edge.
    p_data_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && take) |=> pend_valid);

    // R8: the parked write survives a stall unchanged.
    p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(pend_valid) && $stable(pend_data) && $stable(pend_mask)));

endmodule

// File: rtl/nowait_mem_array.sv
// Word array with byte-lane write mask and combinational read port.
// Assumes: contents are undefined until written; no reset on storage.
module nowait_mem_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        wmask,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit the enabled lanes of a write.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (wmask[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/nowait_sram.sv
// Top: zero-turnaround flow-through synchronous SRAM. Commands register on
// the rising edge, write data follows one cycle later through a parked
// register, reads flow through with one cycle latency and see parked data.
// Assumes: interleave is only changed around load edges; dout is zero
// whenever it is not driven.
module nowait_sram
    import nowait_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    parameter int CNT_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    sel_c,
    input  logic                    load_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    interleave,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int DATA_W = LANES * LANE_W;

    logic              adv;
    logic              selected;
    cyc_t              cyc;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  cur_lanes_n;
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;
    logic [LANES-1:0]  pend_mask;
    logic [DATA_W-1:0] pend_data;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] rd_word;

    assign adv      = !clk_en_n;
    assign selected = !sel_a_n && !sel_b_n && sel_c;

    nowait_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W)) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (adv),
        .load_n      (load_n),
        .wr_n        (wr_n),
        .selected    (selected),
        .interleave  (interleave),
        .lane_en_n   (lane_en_n),
        .addr        (addr),
        .cyc         (cyc),
        .cur_addr    (cur_addr),
        .cur_lanes_n (cur_lanes_n)
    );

    nowait_write_buf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .take       (cyc == CYC_WRITE),
        .wr_addr    (cur_addr),
        .wr_lanes_n (cur_lanes_n),
        .wr_data    (din),
        .rd_addr    (cur_addr),
        .arr_word   (arr_word),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .pend_mask  (pend_mask),
        .pend_data  (pend_data),
        .rd_word    (rd_word)
    );

    nowait_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk   (clk),
        .we    (adv && pend_valid),
        .waddr (pend_addr),
        .wmask (pend_mask),
        .wdata (pend_data),
        .raddr (cur_addr),
        .rdata (arr_word)
    );

    // Drive the bus only for a read cycle with the output enabled.
    always_comb begin
        dout_en = (cyc == CYC_READ) && !oe_n;
        dout    = dout_en ? rd_word : '0;
    end

    // R7: a selected write load never drives the bus in the next cycle.
    p_write_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!clk_en_n && !load_n && !wr_n && !sel_a_n && !sel_b_n && sel_c) |-> !dout_en);

    // R2: a deselecting load leaves the bus undriven.
    p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!clk_en_n && !load_n && !(!sel_a_n && !sel_b_n && sel_c)) |-> !dout_en);

    // R11: the first cycle after reset is quiet.
    p_reset_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !dout_en);

endmodule

// File: tb/nowait_sram_test.sv
`timescale 1ns/1ps
module nowait_sram_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clk_en_n, sel_a_n, sel_b_n, sel_c, load_n, wr_n, interleave, oe_n;
    logic [1:0]  lane_en_n;
    logic [7:0]  addr;
    logic [15:0] din;
    logic [15:0] dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state
    logic [15:0] ref_mem [256];
    logic        m_act, m_wr, m_md;
    logic [1:0]  m_lanes, m_cnt;
    logic [7:0]  m_base;

    always #2 clk = ~clk;

    nowait_sram uut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
        .sel_b_n(sel_b_n), .sel_c(sel_c), .load_n(load_n), .wr_n(wr_n),
        .lane_en_n(lane_en_n), .addr(addr), .interleave(interleave), .din(din),
        .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [7:0] burst_addr(input logic [7:0] b, input logic [1:0] k, input logic md);
        logic [1:0] lo;
        lo = md ? (b[1:0] ^ k) : (b[1:0] + k);
        return {b[7:2], lo};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive inputs, step the model, check outputs after the edge.
    // d is the data phase for the command registered at the previous working edge.
    task automatic op(input logic ld, input logic wr, input logic [1:0] ln, input logic [7:0] a,
                      input logic ok, input logic stl, input logic oe, input logic md,
                      input logic [15:0] d, input string tag);
        logic       exp_en;
        logic [7:0] ea;
        @(negedge clk);
        {sel_a_n, sel_b_n, sel_c} = ok ? 3'b001 : (a[0] ? 3'b101 : (a[1] ? 3'b011 : 3'b000));
        load_n = ld; wr_n = wr; lane_en_n = ln; addr = a;
        clk_en_n = stl; oe_n = oe; interleave = md; din = d;
        @(posedge clk); #1;
        if (!stl) begin
            if (m_act && m_wr) begin
                ea = burst_addr(m_base, m_cnt, m_md);
                if (!m_lanes[0]) ref_mem[ea][7:0]  = d[7:0];
                if (!m_lanes[1]) ref_mem[ea][15:8] = d[15:8];
            end
            m_lanes = ln;
            if (!ld) begin
                m_act = ok; m_wr = !wr; m_base = a; m_cnt = 2'd0; m_md = md;
            end else if (m_act) begin
                m_cnt = m_cnt + 2'd1;
            end
        end
        exp_en = m_act && !m_wr && !oe;
        chk({tag, " dout_en"}, {15'd0, dout_en}, {15'd0, exp_en});
        if (exp_en) chk({tag, " dout"}, dout, ref_mem[burst_addr(m_base, m_cnt, m_md)]);
    endtask

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        m_act = 0; m_wr = 0; m_md = 0; m_lanes = 2'b11; m_cnt = 0; m_base = 0;
        rst_n = 0; clk_en_n = 0; sel_a_n = 1; sel_b_n = 1; sel_c = 0; load_n = 0;
        wr_n = 1; lane_en_n = 2'b11; addr = 0; interleave = 0; oe_n = 0; din = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R11: quiet after reset with output enabled
        chk("R11 reset dout_en", {15'd0, dout_en}, 16'd0);
        // R10: continue right after reset stays deselected
        op(1, 1, 2'b00, 8'h00, 1, 0, 0, 0, 16'h0, "R10");

        // R4: fill the array with full-width writes
        for (int i = 0; i < 256; i++)
            op(0, 0, 2'b00, i[7:0], 1, 0, 0, 0, (i == 0) ? 16'h0 : {i[7:0] - 8'd1, ~(i[7:0] - 8'd1)}, "R4");
        // R6: back-to-back read of the last written word is forwarded
        op(0, 1, 2'b11, 8'hFF, 1, 0, 0, 0, 16'hFF00, "R6");

        // R6: partial write of lane 0, then immediate read merges bytes
        op(0, 0, 2'b10, 8'h0A, 1, 0, 0, 0, 16'h0, "R4");
        op(0, 1, 2'b11, 8'h0A, 1, 0, 0, 0, 16'hABCD, "R6");
        op(0, 1, 2'b11, 8'h0A, 1, 0, 0, 0, 16'h0, "R4");
        // R5: write abort
        op(0, 0, 2'b11, 8'h0B, 1, 0, 0, 0, 16'h0, "R5");
        op(0, 1, 2'b11, 8'h0B, 1, 0, 0, 0, 16'hFFFF, "R5");
        op(0, 1, 2'b11, 8'h0B, 1, 0, 0, 0, 16'h0, "R5");

        // R8: stall during a read holds the bus
        op(0, 1, 2'b11, 8'h14, 1, 0, 0, 0, 16'h0, "R3");
        op(0, 0, 2'b00, 8'h33, 1, 1, 0, 0, 16'h0, "R8");
        // R8: stall during a write: din not taken, bus stays off
        op(0, 0, 2'b00, 8'h15, 1, 0, 0, 0, 16'h0, "R7");
        op(0, 1, 2'b00, 8'h16, 1, 1, 0, 0, 16'h1111, "R8");
        op(0, 1, 2'b11, 8'h15, 1, 0, 0, 0, 16'h2222, "R8");
        op(0, 1, 2'b11, 8'h15, 1, 0, 0, 0, 16'h0, "R8");

        // R3: output enable high suppresses the drive
        op(0, 1, 2'b11, 8'h1E, 1, 0, 1, 0, 16'h0, "R3");
        // R7: write cycle stays undriven with oe low
        op(0, 0, 2'b01, 8'h1F, 1, 0, 0, 0, 16'h0, "R7");
        op(0, 1, 2'b11, 8'h1F, 1, 0, 0, 0, 16'h5A5A, "R6");

        // R2: deselected write changes nothing; deselected read is quiet
        op(0, 0, 2'b00, 8'h28, 0, 0, 0, 0, 16'h0, "R2");
        op(0, 1, 2'b11, 8'h29, 0, 0, 0, 0, 16'hDEAD, "R2");
        op(1, 1, 2'b11, 8'h00, 1, 0, 0, 0, 16'h0, "R10");
        op(0, 1, 2'b11, 8'h28, 1, 0, 0, 0, 16'h0, "R2");

        // R9: linear read burst from 0x45, interleaved from 0x51
        op(0, 1, 2'b11, 8'h45, 1, 0, 0, 0, 16'h0, "R9");
        for (int k = 0; k < 4; k++) op(1, 0, 2'b00, 8'h00, 1, 0, 0, 1, 16'h0, "R9");
        op(0, 1, 2'b11, 8'h51, 1, 0, 0, 1, 16'h0, "R9");
        for (int k = 0; k < 3; k++) op(1, 0, 2'b00, 8'h00, 1, 0, 0, 0, 16'h0, "R9");
        // R9: write burst at 0x62 linear, then read back
        op(0, 0, 2'b00, 8'h62, 1, 0, 0, 0, 16'h0, "R9");
        for (int k = 0; k < 3; k++) op(1, 1, 2'b00, 8'h00, 1, 0, 0, 1, 16'hC000 + 16'(k), "R9");
        op(0, 1, 2'b11, 8'h60, 1, 0, 0, 0, 16'hC003, "R9");
        for (int k = 0; k < 3; k++) op(1, 1, 2'b11, 8'h00, 1, 0, 0, 0, 16'h0, "R9");

        // R1: constrained random mix on a small address window
        for (int n = 0; n < 3000; n++) begin
            logic ld, ok, stl, oe;
            ld  = ($urandom() % 10) < 7;
            ok  = ($urandom() % 10) < 8;
            stl = ($urandom() % 10) == 0;
            oe  = ($urandom() % 10) == 0;
            op(!ld, 1'($urandom()), 2'($urandom()), 8'h80 + 8'($urandom() % 16),
               ok, stl, oe, 1'($urandom()), 16'($urandom()), "R1");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule